// File: doc/BRIEF.md
# RoCEv2 Receive Header Parser

This block sits on the receive side of an RDMA-capable network port. It accepts one Ethernet frame at a time as a byte-wide AXI4-Stream and checks the protocol layers in sequence: MAC header, an optional 802.1Q tag, an IPv4 or IPv6 header, UDP, the InfiniBand base transport header, and at most one extension header. The transport opcode decides which extension header, if any, follows.

When every check passes, the block presents the transport fields on a record bus for exactly one cycle. These fields are the opcode, the destination queue pair, the packet sequence number, the remote-access fields for a read request, and the acknowledge fields for an ACK/NAK. The bytes that follow the last header are forwarded on an output stream, and tlast is kept. A frame that is not RoCEv2, or that ends before its headers are complete, produces no record and no output bytes. Its remaining bytes are consumed at full rate, and a single-cycle rejection flag is raised when its tlast is accepted.

Top module: `roce_rx_parser`

## Requirements
- R1: An untagged IPv4 frame (EtherType 0x0800, first IP byte 0x45, protocol 17) with UDP destination port 4791 yields one record. The record carries the opcode from transport byte 0, the destination QP from transport bytes 5..7 and the PSN from transport bytes 9..11, all most significant byte first.
- R2: A frame carrying an 802.1Q tag (EtherType 0x8100 followed by 4 tag bytes, the last two holding the inner EtherType) is parsed like an untagged one, and the record's VLAN flag is 1. Untagged frames report 0.
- R3: An IPv6 frame (EtherType 0x86DD, top nibble of IP byte 0 equal to 6, next-header byte 6 equal to 17, 40-byte header) is accepted, and the record's IPv6 flag is 1.
- R4: A UDP destination port other than 4791 rejects the frame: the rejection flag pulses, and no record and no output bytes are produced.
- R5: The frame is rejected in the same way for any of these: an EtherType (outer, or inner after a tag) that is neither IPv4 nor IPv6, an IPv4 first byte other than 0x45, an IPv4 protocol other than 17, an IPv6 version other than 6, or an IPv6 next header other than 17.
- R6: Opcode 0x0C (RDMA read request) is followed by a 16-byte extension header: virtual address in bytes 0..7, remote key in 8..11, DMA length in 12..15. The record reports all three and sets its RETH flag.
- R7: Opcode 0x11 (acknowledge/NAK) is followed by a 4-byte extension header: syndrome in byte 0, MSN in bytes 1..3. The record reports both and sets its AETH flag. Other opcodes have no extension header, and both flags are 0.
- R8: For an accepted frame, every byte after the last header is forwarded in order, and tlast appears on the final byte.
- R9: While the output has a byte that is not taken (m_tvalid=1, m_tready=0), the output byte and its tlast stay unchanged, and no payload byte is accepted at the input.
- R10: A frame whose tlast arrives before its headers are complete is rejected. A frame whose tlast is on the final header byte yields a record and no output bytes.
- R11: The record valid and the rejection flag are each high for one cycle per frame, in the cycle after the deciding byte is accepted. During headers and rejected frames, s_tready stays 1 whatever the state of m_tready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Received frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted |
| s_tlast | input | 1 | Final byte of the frame |
| m_tdata | output | 8 | Forwarded payload byte |
| m_tvalid | output | 1 | Payload byte valid |
| m_tready | input | 1 | Downstream accepts payload byte |
| m_tlast | output | 1 | Final payload byte of the frame |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_opcode | output | 8 | Transport opcode |
| rec_dest_qp | output | 24 | Destination queue pair |
| rec_psn | output | 24 | Packet sequence number |
| rec_vlan | output | 1 | Frame carried a VLAN tag |
| rec_ipv6 | output | 1 | Network layer was IPv6 |
| rec_has_reth | output | 1 | Read-request extension header was present |
| rec_vaddr | output | 64 | Remote virtual address |
| rec_rkey | output | 32 | Remote key |
| rec_dma_len | output | 32 | DMA length |
| rec_has_aeth | output | 1 | Acknowledge extension header was present |
| rec_syndrome | output | 8 | Acknowledge syndrome |
| rec_msn | output | 24 | Message sequence number |
| not_roce | output | 1 | One-cycle rejection strobe |

## Verification
The parser is tried with accepted frames that cover each combination of tag presence and IP version. These show whether the header walk moves to the correct offsets for each layout, because a wrong length would misplace the QP and PSN bytes. Opcodes with no extension, the read-request extension and the acknowledge extension show whether the opcode-driven branch chooses the correct length and field positions. Rejected frames, one per check that can fail, each compared against a clean frame, show that every individual check leads to the drain path without stalling. A truncated frame and a frame that ends exactly on its final header byte separate early termination from a completed header with no payload. Payload streams sent under a periodic m_tready pattern show the hold and stall behaviour.

// File: rtl/roce_rx_pkg.sv
package roce_rx_pkg;

  localparam int CNT_W = 6;

  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  localparam logic [15:0] ETYPE_IP4  = 16'h0800;
  localparam logic [15:0] ETYPE_IP6  = 16'h86DD;
  localparam logic [7:0]  IP4_VIHL   = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam logic [7:0]  OP_RD_REQ  = 8'h0C;
  localparam logic [7:0]  OP_ACK     = 8'h11;

  localparam int LEN_ETH  = 14;
  localparam int LEN_VLAN = 4;
  localparam int LEN_IP4  = 20;
  localparam int LEN_IP6  = 40;
  localparam int LEN_UDP  = 8;
  localparam int LEN_BTH  = 12;
  localparam int LEN_RETH = 16;
  localparam int LEN_AETH = 4;

  typedef enum logic [3:0] {
    S_ETH, S_VLAN, S_IP4, S_IP6, S_UDP, S_BTH, S_RETH, S_AETH, S_PAY, S_DRAIN
  } walk_st_t;

  function automatic logic [CNT_W-1:0] hdr_final(input walk_st_t s);
    case (s)
      S_ETH:   hdr_final = CNT_W'(LEN_ETH - 1);
      S_VLAN:  hdr_final = CNT_W'(LEN_VLAN - 1);
      S_IP4:   hdr_final = CNT_W'(LEN_IP4 - 1);
      S_IP6:   hdr_final = CNT_W'(LEN_IP6 - 1);
      S_UDP:   hdr_final = CNT_W'(LEN_UDP - 1);
      S_BTH:   hdr_final = CNT_W'(LEN_BTH - 1);
      S_RETH:  hdr_final = CNT_W'(LEN_RETH - 1);
      S_AETH:  hdr_final = CNT_W'(LEN_AETH - 1);
      default: hdr_final = '1;
    endcase
  endfunction

endpackage

// File: rtl/roce_rx_walk.sv
module roce_rx_walk
  import roce_rx_pkg::*;
#(
  parameter logic [15:0] UDP_PORT = 16'd4791
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [7:0]       din,
  input  logic             dlast,
  input  logic             pay_room,
  output walk_st_t         st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o,
  output logic             rec_o,
  output logic             bad_o
);

  walk_st_t         st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       prev_q;
  logic [7:0]       op_q;
  logic             restart;
  logic             done;
  logic             at_end;
  logic [15:0]      w16;

  assign w16     = {prev_q, din};
  assign at_end  = (cnt == hdr_final(st));
  assign ready_o = (st == S_PAY) ? pay_room : 1'b1;
  assign st_o    = st;
  assign cnt_o   = cnt;

  always_comb begin
    nxt     = st;
    restart = 1'b0;
    done    = 1'b0;
    case (st)
      S_ETH: if (at_end) begin
        restart = 1'b1;
        case (w16)
          ETYPE_VLAN: nxt = S_VLAN;
          ETYPE_IP4:  nxt = S_IP4;
          ETYPE_IP6:  nxt = S_IP6;
          default:    nxt = S_DRAIN;
        endcase
      end
      S_VLAN: if (at_end) begin
        restart = 1'b1;
        case (w16)
          ETYPE_IP4: nxt = S_IP4;
          ETYPE_IP6: nxt = S_IP6;
          default:   nxt = S_DRAIN;
        endcase
      end
      S_IP4: begin
        if ((cnt == 0 && din != IP4_VIHL) || (cnt == 9 && din != PROTO_UDP)) begin
          restart = 1'b1;
          nxt     = S_DRAIN;
        end else if (at_end) begin
          restart = 1'b1;
          nxt     = S_UDP;
        end
      end
      S_IP6: begin
        if ((cnt == 0 && din[7:4] != 4'd6) || (cnt == 6 && din != PROTO_UDP)) begin
          restart = 1'b1;
          nxt     = S_DRAIN;
        end else if (at_end) begin
          restart = 1'b1;
          nxt     = S_UDP;
        end
      end
      S_UDP: begin
        if (cnt == 3 && w16 != UDP_PORT) begin
          restart = 1'b1;
          nxt     = S_DRAIN;
        end else if (at_end) begin
          restart = 1'b1;
          nxt     = S_BTH;
        end
      end
      S_BTH: if (at_end) begin
        restart = 1'b1;
        if (op_q == OP_RD_REQ)   nxt = S_RETH;
        else if (op_q == OP_ACK) nxt = S_AETH;
        else begin
          done = 1'b1;
          nxt  = S_PAY;
        end
      end
      S_RETH, S_AETH: if (at_end) begin
        restart = 1'b1;
        done    = 1'b1;
        nxt     = S_PAY;
      end
      default: ;
    endcase
    if (dlast) begin
      restart = 1'b1;
      nxt     = S_ETH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_ETH;
      cnt    <= '0;
      prev_q <= '0;
      op_q   <= '0;
      rec_o  <= 1'b0;
      bad_o  <= 1'b0;
    end else begin
      rec_o <= beat && done;
      bad_o <= beat && dlast && !done && (st != S_PAY);
      if (beat) begin
        st     <= nxt;
        cnt    <= restart ? '0 : cnt + 1'b1;
        prev_q <= din;
        if (st == S_BTH && cnt == 0) op_q <= din;
      end
    end
  end

endmodule

// File: rtl/roce_rx_fields.sv
module roce_rx_fields
  import roce_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [7:0]       din,
  input  walk_st_t         st,
  input  logic [CNT_W-1:0] cnt,
  output logic [7:0]       opcode,
  output logic [23:0]      dest_qp,
  output logic [23:0]      psn,
  output logic             vlan,
  output logic             ipv6,
  output logic             has_reth,
  output logic [63:0]      vaddr,
  output logic [31:0]      rkey,
  output logic [31:0]      dma_len,
  output logic             has_aeth,
  output logic [7:0]       syndrome,
  output logic [23:0]      msn
);

  logic [55:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      opcode   <= '0;
      dest_qp  <= '0;
      psn      <= '0;
      vlan     <= 1'b0;
      ipv6     <= 1'b0;
      has_reth <= 1'b0;
      vaddr    <= '0;
      rkey     <= '0;
      dma_len  <= '0;
      has_aeth <= 1'b0;
      syndrome <= '0;
      msn      <= '0;
    end else if (beat) begin
      win_q <= {win_q[47:0], din};
      case (st)
        S_ETH: if (cnt == 0) begin
          vlan <= 1'b0;
          ipv6 <= 1'b0;
        end
        S_VLAN: vlan <= 1'b1;
        S_IP6:  ipv6 <= 1'b1;
        S_BTH: begin
          if (cnt == 0) begin
            opcode   <= din;
            has_reth <= 1'b0;
            has_aeth <= 1'b0;
            vaddr    <= '0;
            rkey     <= '0;
            dma_len  <= '0;
            syndrome <= '0;
            msn      <= '0;
          end
          if (cnt == 7)  dest_qp <= {win_q[15:0], din};
          if (cnt == 11) psn     <= {win_q[15:0], din};
        end
        S_RETH: begin
          has_reth <= 1'b1;
          if (cnt == 7)  vaddr   <= {win_q, din};
          if (cnt == 11) rkey    <= {win_q[23:0], din};
          if (cnt == 15) dma_len <= {win_q[23:0], din};
        end
        S_AETH: begin
          has_aeth <= 1'b1;
          if (cnt == 0) syndrome <= din;
          if (cnt == 3) msn      <= {win_q[15:0], din};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/roce_rx_outq.sv
module roce_rx_outq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          dlast,
  output logic          room,
  output logic [DW-1:0] o_data,
  output logic          o_valid,
  output logic          o_last,
  input  logic          o_ready
);

  assign room = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_data  <= din;
      o_last  <= dlast;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/roce_rx_parser.sv
module roce_rx_parser
  import roce_rx_pkg::*;
#(
  parameter logic [15:0] UDP_PORT = 16'd4791
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        rec_valid,
  output logic [7:0]  rec_opcode,
  output logic [23:0] rec_dest_qp,
  output logic [23:0] rec_psn,
  output logic        rec_vlan,
  output logic        rec_ipv6,
  output logic        rec_has_reth,
  output logic [63:0] rec_vaddr,
  output logic [31:0] rec_rkey,
  output logic [31:0] rec_dma_len,
  output logic        rec_has_aeth,
  output logic [7:0]  rec_syndrome,
  output logic [23:0] rec_msn,
  output logic        not_roce
);

  walk_st_t         walk_st;
  logic [CNT_W-1:0] walk_cnt;
  logic             beat;
  logic             pay_room;
  logic             pay_load;

  assign beat     = s_tvalid && s_tready;
  assign pay_load = beat && (walk_st == S_PAY);

  roce_rx_walk #(.UDP_PORT(UDP_PORT)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .din      (s_tdata),
    .dlast    (s_tlast),
    .pay_room (pay_room),
    .st_o     (walk_st),
    .cnt_o    (walk_cnt),
    .ready_o  (s_tready),
    .rec_o    (rec_valid),
    .bad_o    (not_roce)
  );

  roce_rx_fields u_fields (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .din      (s_tdata),
    .st       (walk_st),
    .cnt      (walk_cnt),
    .opcode   (rec_opcode),
    .dest_qp  (rec_dest_qp),
    .psn      (rec_psn),
    .vlan     (rec_vlan),
    .ipv6     (rec_ipv6),
    .has_reth (rec_has_reth),
    .vaddr    (rec_vaddr),
    .rkey     (rec_rkey),
    .dma_len  (rec_dma_len),
    .has_aeth (rec_has_aeth),
    .syndrome (rec_syndrome),
    .msn      (rec_msn)
  );

  roce_rx_outq #(.DW(8)) u_outq (
    .clk     (clk),
    .rst     (rst),
    .load    (pay_load),
    .din     (s_tdata),
    .dlast   (s_tlast),
    .room    (pay_room),
    .o_data  (m_tdata),
    .o_valid (m_tvalid),
    .o_last  (m_tlast),
    .o_ready (m_tready)
  );

endmodule

// File: rtl/roce_rx_chk.sv
module roce_rx_chk
  import roce_rx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       s_tready,
  input logic [7:0] m_tdata,
  input logic       m_tvalid,
  input logic       m_tready,
  input logic       m_tlast,
  input logic       rec_valid,
  input logic [7:0] rec_opcode,
  input logic       rec_has_reth,
  input logic       rec_has_aeth,
  input logic       not_roce,
  input walk_st_t   st
);

  p_rec_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  p_rec_vs_reject_r4: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid && not_roce));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_in_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PAY && m_tvalid && !m_tready) |-> !s_tready);

  p_hdr_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (st != S_PAY) |-> s_tready);

  p_ext_excl_r7: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $onehot0({rec_has_reth, rec_has_aeth}));

  p_reth_op_r6: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_has_reth == (rec_opcode == OP_RD_REQ)));

  p_aeth_op_r7: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_has_aeth == (rec_opcode == OP_ACK)));

endmodule

bind roce_rx_parser roce_rx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .s_tready     (s_tready),
  .m_tdata      (m_tdata),
  .m_tvalid     (m_tvalid),
  .m_tready     (m_tready),
  .m_tlast      (m_tlast),
  .rec_valid    (rec_valid),
  .rec_opcode   (rec_opcode),
  .rec_has_reth (rec_has_reth),
  .rec_has_aeth (rec_has_aeth),
  .not_roce     (not_roce),
  .st           (walk_st)
);

// File: tb/sim_roce_rx_parser.sv
`timescale 1ns/1ps
module sim_roce_rx_parser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tlast;
  logic        rec_valid;
  logic [7:0]  rec_opcode;
  logic [23:0] rec_dest_qp, rec_psn, rec_msn;
  logic        rec_vlan, rec_ipv6, rec_has_reth, rec_has_aeth;
  logic [63:0] rec_vaddr;
  logic [31:0] rec_rkey, rec_dma_len;
  logic [7:0]  rec_syndrome;
  logic        not_roce;

  always #10 clk = ~clk;

  roce_rx_parser u0 (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .rec_valid(rec_valid), .rec_opcode(rec_opcode), .rec_dest_qp(rec_dest_qp),
    .rec_psn(rec_psn), .rec_vlan(rec_vlan), .rec_ipv6(rec_ipv6),
    .rec_has_reth(rec_has_reth), .rec_vaddr(rec_vaddr), .rec_rkey(rec_rkey),
    .rec_dma_len(rec_dma_len), .rec_has_aeth(rec_has_aeth),
    .rec_syndrome(rec_syndrome), .rec_msn(rec_msn), .not_roce(not_roce)
  );

  typedef struct {
    bit          reject;
    logic [7:0]  op;
    logic [23:0] qp, psn;
    bit          vlan, ip6, reth, aeth;
    logic [63:0] va;
    logic [31:0] rk, ln;
    logic [7:0]  syn;
    logic [23:0] msn;
    string       tag;
  } exp_t;

  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } pay_t;

  exp_t       evq[$];
  pay_t       payq[$];
  logic [7:0] fq[$];
  int         nchk = 0;
  int         nerr = 0;
  int         stalls = 0;
  bit         bp_mode = 1'b0;
  bit         finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------- frame builders ----------
  task automatic put(input logic [7:0] b); fq.push_back(b); endtask
  task automatic put16(input logic [15:0] v); put(v[15:8]); put(v[7:0]); endtask

  task automatic net_hdr(input bit vlan, input bit ip6, input logic [7:0] vbyte,
                         input logic [7:0] proto, input logic [15:0] port);
    for (int i = 0; i < 12; i++) put(8'hA0 + 8'(i));
    if (vlan) begin put16(16'h8100); put16(16'h0005); end
    put16(ip6 ? 16'h86DD : 16'h0800);
    if (!ip6) begin
      put(vbyte);
      for (int i = 1; i < 9; i++) put(8'h10 + 8'(i));
      put(proto);
      for (int i = 10; i < 20; i++) put(8'h20 + 8'(i));
    end else begin
      put(vbyte);
      for (int i = 1; i < 6; i++) put(8'h30 + 8'(i));
      put(proto);
      for (int i = 7; i < 40; i++) put(8'h40 + 8'(i));
    end
    put16(16'hC001); put16(port); put16(16'h0040); put16(16'h0000);
  endtask

  task automatic bth(input logic [7:0] op, input logic [23:0] qp, input logic [23:0] psn);
    put(op); put(8'h00); put16(16'hFFFF); put(8'h00);
    put(qp[23:16]); put(qp[15:8]); put(qp[7:0]);
    put(8'h80); put(psn[23:16]); put(psn[15:8]); put(psn[7:0]);
  endtask

  task automatic payload(input int n, input logic [7:0] seed, input string tag);
    for (int i = 0; i < n; i++) begin
      pay_t p;
      p.d = seed + 8'(i * 7);
      p.l = (i == n - 1);
      p.tag = tag;
      put(p.d);
      payq.push_back(p);
    end
  endtask

  function automatic exp_t mk(input string tag, input logic [7:0] op, input logic [23:0] qp,
                              input logic [23:0] psn, input bit vlan, input bit ip6);
    exp_t e;
    e.reject = 1'b0; e.op = op; e.qp = qp; e.psn = psn; e.vlan = vlan; e.ip6 = ip6;
    e.reth = 1'b0; e.aeth = 1'b0; e.va = '0; e.rk = '0; e.ln = '0; e.syn = '0; e.msn = '0;
    e.tag = tag;
    return e;
  endfunction

  task automatic expect_reject(input string tag);
    exp_t e;
    e = mk(tag, 8'h00, 24'h0, 24'h0, 1'b0, 1'b0);
    e.reject = 1'b1;
    evq.push_back(e);
  endtask

  // ---------- driver ----------
  task automatic send();
    stalls = 0;
    for (int i = 0; i < fq.size(); i++) begin
      s_tvalid = 1'b1;
      s_tdata  = fq[i];
      s_tlast  = (i == fq.size() - 1);
      #1;
      while (!s_tready) begin
        @(negedge clk); #1;
        stalls++;
      end
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    fq.delete();
    repeat (2) @(negedge clk);
  endtask

  // ---------- ready pattern ----------
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    m_tready <= bp_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // ---------- monitor ----------
  bit         hold_q = 1'b0;
  logic [7:0] hold_d;
  logic       hold_l;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if (hold_q) begin
          chk("R9 output held under backpressure", {m_tvalid, m_tlast, m_tdata}, {1'b1, hold_l, hold_d});
        end
        hold_q = m_tvalid && !m_tready;
        hold_d = m_tdata;
        hold_l = m_tlast;
        if (rec_valid || not_roce) begin
          if (evq.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL R4 unexpected strobe: actual rec=%0b rej=%0b expected none", rec_valid, not_roce);
          end else begin
            exp_t e;
            e = evq.pop_front();
            chk({e.tag, " strobe kind"}, {rec_valid, not_roce}, {!e.reject, e.reject});
            if (!e.reject && rec_valid) begin
              chk({e.tag, " R1 opcode"}, rec_opcode, e.op);
              chk({e.tag, " R1 dest qp"}, rec_dest_qp, e.qp);
              chk({e.tag, " R1 psn"}, rec_psn, e.psn);
              chk({e.tag, " R2/R3 vlan,ipv6"}, {rec_vlan, rec_ipv6}, {e.vlan, e.ip6});
              chk({e.tag, " R6/R7 ext flags"}, {rec_has_reth, rec_has_aeth}, {e.reth, e.aeth});
              if (e.reth) begin
                chk({e.tag, " R6 vaddr"}, rec_vaddr, e.va);
                chk({e.tag, " R6 rkey,len"}, {rec_rkey, rec_dma_len}, {e.rk, e.ln});
              end
              if (e.aeth) chk({e.tag, " R7 syndrome,msn"}, {rec_syndrome, rec_msn}, {e.syn, e.msn});
            end
          end
        end
        if (m_tvalid && m_tready) begin
          if (payq.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL R8 unexpected payload: actual %h expected none", m_tdata);
          end else begin
            pay_t p;
            p = payq.pop_front();
            chk({p.tag, " R8 payload byte,last"}, {m_tlast, m_tdata}, {p.l, p.d});
          end
        end
      end
    end
  end

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------- stimulus ----------
  initial begin
    exp_t e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R11 reset strobes idle", {rec_valid, not_roce, m_tvalid}, 3'b000);
    chk("R11 reset ready", s_tready, 1'b1);
    @(negedge clk);

    // R1: untagged IPv4 send with payload
    net_hdr(1'b0, 1'b0, 8'h45, 8'd17, 16'd4791);
    bth(8'h04, 24'h123456, 24'hABCDEF);
    evq.push_back(mk("R1", 8'h04, 24'h123456, 24'hABCDEF, 1'b0, 1'b0));
    payload(5, 8'h11, "R1");
    send();

    // R2: tagged IPv4
    net_hdr(1'b1, 1'b0, 8'h45, 8'd17, 16'd4791);
    bth(8'h00, 24'h000102, 24'h000001);
    evq.push_back(mk("R2", 8'h00, 24'h000102, 24'h000001, 1'b1, 1'b0));
    payload(4, 8'h50, "R2");
    send();

    // R3: untagged IPv6
    net_hdr(1'b0, 1'b1, 8'h60, 8'd17, 16'd4791);
    bth(8'h04, 24'hFEDCBA, 24'h00FF00);
    evq.push_back(mk("R3", 8'h04, 24'hFEDCBA, 24'h00FF00, 1'b0, 1'b1));
    payload(3, 8'h90, "R3");
    send();

    // R6 + R10: tagged IPv6 read request, ends on final header byte
    net_hdr(1'b1, 1'b1, 8'h60, 8'd17, 16'd4791);
    bth(8'h0C, 24'h00AA55, 24'h345678);
    put16(16'h0123); put16(16'h4567); put16(16'h89AB); put16(16'hCDEF);
    put16(16'hDEAD); put16(16'hBEEF); put16(16'h0000); put16(16'h1000);
    e = mk("R6 R10", 8'h0C, 24'h00AA55, 24'h345678, 1'b1, 1'b1);
    e.reth = 1'b1; e.va = 64'h0123456789ABCDEF; e.rk = 32'hDEADBEEF; e.ln = 32'h00001000;
    evq.push_back(e);
    send();

    // R7: IPv4 acknowledge
    net_hdr(1'b0, 1'b0, 8'h45, 8'd17, 16'd4791);
    bth(8'h11, 24'h000777, 24'h101010);
    put(8'h60); put(8'h0A); put(8'h0B); put(8'h0C);
    e = mk("R7", 8'h11, 24'h000777, 24'h101010, 1'b0, 1'b0);
    e.aeth = 1'b1; e.syn = 8'h60; e.msn = 24'h0A0B0C;
    evq.push_back(e);
    payload(2, 8'h33, "R7");
    send();

    // R4: wrong port, payload must not appear; R11 no stall even with backpressure
    bp_mode = 1'b1;
    net_hdr(1'b0, 1'b0, 8'h45, 8'd17, 16'd4790);
    bth(8'h04, 24'h1, 24'h2);
    for (int i = 0; i < 10; i++) put(8'hEE);
    expect_reject("R4");
    send();
    chk("R11 reject frame drained without stall", stalls, 0);
    bp_mode = 1'b0;

    // R5: non-IP EtherType
    for (int i = 0; i < 12; i++) put(8'hA0);
    put16(16'h0806);
    for (int i = 0; i < 30; i++) put(8'h01);
    expect_reject("R5 ethertype");
    send();

    // R5: IPv4 protocol not UDP
    net_hdr(1'b0, 1'b0, 8'h45, 8'd6, 16'd4791);
    bth(8'h04, 24'h1, 24'h2);
    expect_reject("R5 ipv4 proto");
    send();

    // R5: IPv6 next header not UDP
    net_hdr(1'b1, 1'b1, 8'h60, 8'd6, 16'd4791);
    bth(8'h04, 24'h1, 24'h2);
    expect_reject("R5 ipv6 nh");
    send();

    // R5: IPv4 with options
    net_hdr(1'b0, 1'b0, 8'h46, 8'd17, 16'd4791);
    bth(8'h04, 24'h1, 24'h2);
    expect_reject("R5 ipv4 ihl");
    send();

    // R5: IPv6 EtherType with wrong version nibble
    net_hdr(1'b0, 1'b1, 8'h40, 8'd17, 16'd4791);
    bth(8'h04, 24'h1, 24'h2);
    expect_reject("R5 ipv6 version");
    send();

    // R10: truncated inside IPv4 header
    net_hdr(1'b0, 1'b0, 8'h45, 8'd17, 16'd4791);
    while (fq.size() > 24) void'(fq.pop_back());
    expect_reject("R10 truncated");
    send();
    chk("R11 truncated frame no stall", stalls, 0);

    // R9: long payload under backpressure, then acknowledge under backpressure
    bp_mode = 1'b1;
    net_hdr(1'b0, 1'b0, 8'h45, 8'd17, 16'd4791);
    bth(8'h2A, 24'h0C0C0C, 24'hFFFFFF);
    evq.push_back(mk("R9", 8'h2A, 24'h0C0C0C, 24'hFFFFFF, 1'b0, 1'b0));
    payload(20, 8'h07, "R9");
    send();
    net_hdr(1'b1, 1'b0, 8'h45, 8'd17, 16'd4791);
    bth(8'h11, 24'h000001, 24'h000002);
    put(8'h00); put(8'h00); put(8'h00); put(8'h05);
    e = mk("R7 bp", 8'h11, 24'h000001, 24'h000002, 1'b1, 1'b0);
    e.aeth = 1'b1; e.syn = 8'h00; e.msn = 24'h000005;
    evq.push_back(e);
    payload(6, 8'hC0, "R9 bp");
    send();
    bp_mode = 1'b0;

    for (int i = 0; i < 200; i++) begin
      if (evq.size() == 0 && payq.size() == 0) break;
      @(negedge clk);
    end
    chk("R8 all expected records and bytes seen", {32'(evq.size()), 32'(payq.size())}, 64'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule